// File: doc/BRIEF.md
# Masked GPIO Output Port Controller

This block holds the output value of a 32-pin general-purpose port behind a small memory-mapped register interface. Software never writes the output value directly. It writes ones to a set alias or a clear alias, and each one drives the matching pin high or low. Zero bits leave their pins alone. This lets separate pieces of software change disjoint pins without a read-modify-write sequence.

Three per-pin filters decide whether a written one reaches a pin. The first is a software mask register, where a mask bit of 1 blocks the pin. The other two are the pin direction and the function-select inputs: only a pin that is an output and assigned to GPIO responds. Every register can be reached as a full word, as one of two half-words, or as one of four bytes. The narrow access carries its data right-aligned on the data bus and the address selects the lane. Reads are combinational and return the selected lane right-aligned.

The pin output-enable is derived from direction and function. Whenever the enable is low, the pad driver outside this block floats the pin.

Top module: `gpio_port`

## Requirements
- R1: After reset the output value and the mask register are all zeros, so reads of the set alias and of the mask both return 0.
- R2: A write to the set alias (register index 0, address bits [3:2] = 0) drives high every enabled, unmasked pin whose write bit is 1. The change is visible from the clock edge that accepts the write.
- R3: A write to the clear alias (register index 1) drives low every enabled, unmasked pin whose write bit is 1.
- R4: Zero bits in a set or clear write leave the corresponding pins unchanged.
- R5: A set or clear write has no effect on a pin whose direction input is 0 (input) or whose function input is 0 (secondary function).
- R6: The mask register (register index 2) is read/write. A mask bit of 1 blocks set and clear writes to that pin, and a mask bit of 0 allows them.
- R7: Access size is given on bus_size: 0 = byte, 1 = half-word, 2 = word, 3 = reserved. A reserved-size write changes nothing and a reserved-size read returns 0.
- R8: A half-word access uses address bit 1 to select pins 0–15 (bit 1 = 0) or pins 16–31 (bit 1 = 1). The lane travels on data bits 15:0.
- R9: A byte access uses address bits [1:0] = k to select pins 8k to 8k+7. The lane travels on data bits 7:0, with data bit 0 mapped to pin 8k.
- R10: A read of the set alias returns the current output value of the selected lane, and a read of the clear alias always returns 0.
- R11: pin_oe is the bitwise AND of pin_dir and pin_func_gpio, and pin_out never changes in a cycle without an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, accepted in the cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address: [3:2] register index, [1:0] lane offset |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data, narrow lanes right-aligned |
| bus_rdata | output | 32 | Read data, narrow lanes right-aligned |
| pin_dir | input | 32 | Per-pin direction, 1 = output |
| pin_func_gpio | input | 32 | Per-pin function select, 1 = GPIO |
| pin_out | output | 32 | Output value register |
| pin_oe | output | 32 | Per-pin output enable for the pad driver |

## Verification
The bench builds the block with its default 32-bit data width and 4-bit address. At that size every combination of access size code, lane offset and set-or-clear operation can be swept, each with several data patterns. Each write is followed by a read-back of the same lane. With that sweep, every byte and half-word lane mapping and the reserved size code are exercised against an arithmetic model. Targeted sequences then cover partial direction and function patterns, masked pins and zero-data writes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RG_SET  = 2'd0,
        RG_CLR  = 2'd1,
        RG_MASK = 2'd2,
        RG_NONE = 2'd3
    } reg_idx_e;

endpackage

// File: rtl/gpio_lane_decode.sv
module gpio_lane_decode
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]                  size,
    input  logic [$clog2(DATA_W/8)-1:0] offs,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           lane_en,
    output logic [DATA_W-1:0]           lane_data,
    output logic [$clog2(DATA_W)-1:0]   rd_shift,
    output logic [DATA_W-1:0]           rd_width
);
    localparam int OFF_W = $clog2(DATA_W/8);
    localparam int SH_W  = $clog2(DATA_W);

    logic [DATA_W-1:0] width_m;
    logic [SH_W-1:0]   sh;

    always_comb begin
        width_m = '0;
        sh      = '0;
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                width_m = {{(DATA_W-8){1'b0}}, 8'hFF};
                sh      = {offs, 3'b000};
            end
            SZ_HALF: begin
                width_m = {{(DATA_W-16){1'b0}}, 16'hFFFF};
                sh      = {offs[OFF_W-1:1], 4'b0000};
            end
            SZ_WORD: begin
                width_m = '1;
                sh      = '0;
            end
            SZ_RSVD: begin
                width_m = '0;
                sh      = '0;
            end
        endcase
    end

    assign lane_en   = width_m << sh;
    assign lane_data = (wdata & width_m) << sh;
    assign rd_shift  = sh;
    assign rd_width  = width_m;

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] set_bits,
    input  logic [NUM_PINS-1:0] clr_bits,
    output logic [NUM_PINS-1:0] value_q
);
    logic [NUM_PINS-1:0] value_d;

    // clear has priority if both ever target one pin
    always_comb begin
        value_d = (value_q | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [NUM_PINS-1:0] lane_en,
    input  logic [NUM_PINS-1:0] lane_data,
    output logic [NUM_PINS-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mask_q <= '0;
        else if (wr) mask_q <= (mask_q & ~lane_en) | (lane_data & lane_en);
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_dir,
    input  logic [DATA_W-1:0] pin_func_gpio,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe
);
    localparam int OFF_W = $clog2(DATA_W/8);
    localparam int SH_W  = $clog2(DATA_W);

    reg_idx_e          idx;
    logic [DATA_W-1:0] lane_en, lane_data, rd_width;
    logic [SH_W-1:0]   rd_shift;
    logic [DATA_W-1:0] mask_q, out_q, gate, set_bits, clr_bits, rd_src;
    logic              wr_acc, mask_wr;

    assign idx    = reg_idx_e'(bus_addr[OFF_W+1:OFF_W]);
    assign wr_acc = bus_sel && bus_we;

    gpio_lane_decode #(.DATA_W(DATA_W)) u_dec (
        .size      (bus_size),
        .offs      (bus_addr[OFF_W-1:0]),
        .wdata     (bus_wdata),
        .lane_en   (lane_en),
        .lane_data (lane_data),
        .rd_shift  (rd_shift),
        .rd_width  (rd_width)
    );

    assign pin_oe = pin_dir & pin_func_gpio;
    assign gate   = lane_en & lane_data & ~mask_q & pin_oe;

    always_comb begin
        set_bits = '0;
        clr_bits = '0;
        mask_wr  = 1'b0;
        if (wr_acc) begin
            unique case (idx)
                RG_SET:  set_bits = gate;
                RG_CLR:  clr_bits = gate;
                RG_MASK: mask_wr  = 1'b1;
                RG_NONE: ;
            endcase
        end
    end

    gpio_out_reg #(.NUM_PINS(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .clr_bits (clr_bits),
        .value_q  (out_q)
    );

    gpio_mask_reg #(.NUM_PINS(DATA_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (mask_wr),
        .lane_en   (lane_en),
        .lane_data (lane_data),
        .mask_q    (mask_q)
    );

    always_comb begin
        unique case (idx)
            RG_SET:  rd_src = out_q;
            RG_MASK: rd_src = mask_q;
            RG_CLR:  rd_src = '0;
            RG_NONE: rd_src = '0;
        endcase
    end

    assign bus_rdata = (bus_sel && !bus_we) ? ((rd_src >> rd_shift) & rd_width) : '0;
    assign pin_out   = out_q;

endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pin_out,
    input logic [DATA_W-1:0] pin_oe,
    input logic [DATA_W-1:0] mask_q
);
    a_r11_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=> $stable(pin_out));

    a_r5_disabled_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

    a_r6_masked_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0));

    a_r10_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr[ADDR_W-1:ADDR_W-2] == 2'd1) |-> (bus_rdata == '0));

    a_r3_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr[ADDR_W-1:ADDR_W-2] == 2'd1 && bus_size == 2'd2)
        |=> ((pin_out & $past(bus_wdata & pin_oe & ~mask_q)) == '0));

    a_r7_reserved_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_size == 2'd3) |=> $stable(pin_out));

endmodule

bind gpio_port gpio_port_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mask_q    (mask_q)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pin_dir = '0, pin_func_gpio = '0, pin_out, pin_oe;

    int checks = 0, errors = 0;
    logic [31:0] exp_out = '0, exp_mask = '0;

    always #5 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_dir(pin_dir), .pin_func_gpio(pin_func_gpio),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [31:0] width_of(int sz);
        case (sz)
            0: return 32'h0000_00FF;
            1: return 32'h0000_FFFF;
            2: return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic int shift_of(int sz, int off);
        case (sz)
            0: return 8 * off;
            1: return 16 * (off / 2);
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(int idx, int sz, int off, logic [31:0] d);
        logic [31:0] en, dat, ok;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1;
        bus_addr = 4'(idx * 4 + off); bus_size = 2'(sz); bus_wdata = d;
        en  = width_of(sz) << shift_of(sz, off);
        dat = (d & width_of(sz)) << shift_of(sz, off);
        ok  = en & dat & ~exp_mask & pin_dir & pin_func_gpio;
        if (idx == 0) exp_out = exp_out | ok;
        if (idx == 1) exp_out = exp_out & ~ok;
        if (idx == 2) exp_mask = (exp_mask & ~en) | (dat & en);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(int idx, int sz, int off, output logic [31:0] r);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0;
        bus_addr = 4'(idx * 4 + off); bus_size = 2'(sz);
        #1 r = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic run_all();
        logic [31:0] r;
        logic [31:0] pats [3] = '{32'hFFFF_FFFF, 32'hA5C3_5A3C, 32'h1248_8421};
        // R1: reset state
        check("R1 out", pin_out, 32'h0);
        bus_read(0, 2, 0, r); check("R1 set read", r, 32'h0);
        bus_read(2, 2, 0, r); check("R1 mask read", r, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        pin_dir = '1; pin_func_gpio = '1;
        // sweep: R2 R3 R7 R8 R9 R10
        for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 4; off++)
                for (int p = 0; p < 3; p++) begin
                    bus_write(0, sz, off, pats[p]);
                    check(sz == 3 ? "R7 set" : sz == 1 ? "R8 set" : sz == 0 ? "R9 set" : "R2 set", pin_out, exp_out);
                    bus_read(0, sz, off, r);
                    check("R10 set read", r, (exp_out >> shift_of(sz, off)) & width_of(sz));
                    bus_write(1, sz, off, pats[(p + 1) % 3]);
                    check(sz == 3 ? "R7 clr" : sz == 1 ? "R8 clr" : sz == 0 ? "R9 clr" : "R3 clr", pin_out, exp_out);
                    bus_read(1, sz, off, r);
                    check("R10 clr read", r, 32'h0);
                end
        // R4: zero bits have no effect
        bus_write(0, 2, 0, 32'h0F0F_F0F0); check("R2 set word", pin_out, 32'h0F0F_F0F0);
        bus_write(0, 2, 0, 32'h0);         check("R4 set zeros", pin_out, 32'h0F0F_F0F0);
        bus_write(1, 2, 0, 32'h0);         check("R4 clr zeros", pin_out, 32'h0F0F_F0F0);
        bus_write(1, 2, 0, 32'hFFFF_FFFF); check("R3 clr all", pin_out, 32'h0);
        // R5 / R11: direction and function gating
        pin_dir = 32'hF0F0_A5A5; pin_func_gpio = 32'hFF00_FF0F;
        #1 check("R11 oe", pin_oe, 32'hF000_A505);
        bus_write(0, 2, 0, 32'hFFFF_FFFF); check("R5 set gated", pin_out, 32'hF000_A505);
        pin_dir = '1; pin_func_gpio = '1;
        bus_write(0, 2, 0, 32'hFFFF_FFFF); check("R2 set all", pin_out, 32'hFFFF_FFFF);
        pin_dir = 32'h0000_FFFF;
        bus_write(1, 2, 0, 32'hFFFF_FFFF); check("R5 clr gated", pin_out, 32'hFFFF_0000);
        pin_dir = '1;
        bus_write(1, 2, 0, 32'hFFFF_FFFF); check("R3 clr all", pin_out, 32'h0);
        // R6: mask register
        bus_write(2, 2, 0, 32'h0000_FFFF);
        bus_read(2, 2, 0, r); check("R6 mask read", r, 32'h0000_FFFF);
        bus_write(2, 0, 3, 32'h0000_0081);
        bus_read(2, 2, 0, r); check("R6 mask byte", r, 32'h8100_FFFF);
        bus_write(0, 2, 0, 32'hFFFF_FFFF); check("R6 set masked", pin_out, 32'h7EFF_0000);
        bus_write(1, 1, 2, 32'h0000_FFFF); check("R6 clr masked", pin_out, 32'h8100_0000 & 32'h0);
        bus_write(2, 2, 0, 32'h0);
        bus_write(0, 1, 0, 32'h0000_1234); check("R6 unmasked", pin_out, 32'h0000_1234);
        check("R6 model", pin_out, exp_out);
        // R11: idle cycles keep value
        repeat (3) @(negedge clk);
        check("R11 idle", pin_out, 32'h0000_1234);
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            run_all();
            begin repeat (100000) @(posedge clk); timed_out = 1'b1; end
        join_any
        if (timed_out) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule